// File: doc/BRIEF.md
# PLL Coefficient Search Engine

The block is a sequential solver that picks divider settings for a frequency synthesizer. Given a requested output frequency and the reference frequency, both in kHz, it searches for an input divider M, a feedback multiplier N and a post-divider index PL. The output it aims for is `ref * N / M / post_divide(PL)`, and it picks the settings that land closest to the request. Every candidate must keep the oscillator (VCO) frequency, the comparison frequency `ref / M` and the M and N values inside parameterised limits.

Control software places the request on the inputs and pulses `start`. It waits for the one-cycle `done` pulse and then reads the settings, the achieved frequency and a flag that marks a failed search. All arithmetic goes through one shared iterative divider, so the search takes many cycles but needs little area. In best-fit mode the search only stops early on an exact hit. Otherwise it also stops as soon as the relative error is small enough.

Top module: `pll_coef_search`

## Requirements
- R1: After reset `busy`, `done`, `no_fit` and `freq_khz` are 0, `m_div` is M_MAX (255), `n_mul` is N_MIN (8) and `pl_idx` is PL_MIN (1).
- R2: A `start` seen while idle raises `busy` on the next cycle. Completion gives `done` high for exactly one cycle with `busy` low. A `start` seen while `busy` is high is ignored, and the result is that of the accepted request.
- R3: A request below F_MIN (144000) or above F_MAX (2064000) is clamped to that limit before the search starts.
- R4: The post-divide values for PL indices 0 to 14 are 1,2,3,4,5,6,8,10,12,16,12,16,20,24,32. The window target is T = req + req/50. If VCO_MAX < T, the VCO upper limit becomes T. The window bounds are hi = ceil(vmax/T) and lo = floor(VCO_MIN/T). Each bound is clamped to [PL_MIN, PL_MAX] and then mapped to the lowest index in 0..13 whose divide value is at least the bound, or to 13 if there is none. Indices lo..hi are scanned in increasing order.
- R5: For each index, M goes up from M_MIN. If ref/M < U_MIN (12000), the M loop for that index ends. If ref/M > U_MAX (38000), that M is skipped.
- R6: With V = req·div(PL), N runs from floor(V·M/ref) to ceil(V·M/ref). Values below N_MIN (8) are skipped. If the floor exceeds N_MAX (255), the M loop ends.
- R7: A candidate has vco = floor(ref·N/M). It is accepted only if VCO_MIN ≤ vco ≤ vmax. Its output is (vco + div/2)/div, rounded to nearest. It becomes the new best only if its absolute error is strictly smaller than the best so far.
- R8: The search stops at the first candidate with zero error.
- R9: With `best_fit` = 0, the search also stops when an improving candidate has floor(vco/error) > 218.
- R10: `freq_khz` = floor(ref·N / (M·div(PL))) for the reported settings.
- R11: If no candidate is accepted, `no_fit` is 1 and the settings stay at M_MAX, N_MIN, PL_MIN.
- R12: The outputs change only in the cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (taken only while idle) |
| best_fit | input | 1 | 1: stop only on an exact hit; 0: also stop on the error-ratio rule |
| req_khz | input | FW | Requested output frequency in kHz |
| ref_khz | input | FW | Reference frequency in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| m_div | output | MW | Chosen input divider |
| n_mul | output | NW | Chosen feedback multiplier |
| pl_idx | output | 4 | Chosen post-divider index |
| freq_khz | output | FW | Achieved output frequency in kHz |
| no_fit | output | 1 | No candidate met the limits |

## Verification
The engine is driven with requests that give an exact hit on the second scanned index, and with a request where best-fit and ratio-stop modes produce different results. Both halves of that pair are run. Requests outside both output limits are also used, and they separate clamping from raising the VCO upper limit. A low reference shows the failed-search defaults. A high reference makes the first M too fast, so it must be skipped. Further references allow several M values per index, and their results are compared with a bench model. These cases test the loop exits, the rounding and the truncated frequency report.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

   typedef enum logic [3:0] {
      S_IDLE, S_TGT, S_WHI, S_WLO, S_PLSET, S_MUF, S_MN,
      S_NCHK, S_NVCO, S_NLWV, S_NXTM, S_NXTPL, S_FIN
   } pcs_state_t;

   localparam int PL_LAST = 13;

   function automatic logic [5:0] pl_div(input logic [3:0] idx);
      case (idx)
         4'd0:  pl_div = 6'd1;
         4'd1:  pl_div = 6'd2;
         4'd2:  pl_div = 6'd3;
         4'd3:  pl_div = 6'd4;
         4'd4:  pl_div = 6'd5;
         4'd5:  pl_div = 6'd6;
         4'd6:  pl_div = 6'd8;
         4'd7:  pl_div = 6'd10;
         4'd8:  pl_div = 6'd12;
         4'd9:  pl_div = 6'd16;
         4'd10: pl_div = 6'd12;
         4'd11: pl_div = 6'd16;
         4'd12: pl_div = 6'd20;
         4'd13: pl_div = 6'd24;
         default: pl_div = 6'd32;
      endcase
   endfunction

endpackage

// File: rtl/pcs_divider.sv
module pcs_divider #(
   parameter int W = 48
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   output logic [W-1:0] quo,
   output logic [W-1:0] rem,
   output logic         done
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  qr, rr, dr;
   logic [CW-1:0] cnt;
   logic          run;
   logic [W:0]    rw, rw_sub;

   assign rw     = {rr, qr[W-1]};
   assign rw_sub = rw - {1'b0, dr};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qr   <= '0;
         rr   <= '0;
         dr   <= '0;
         cnt  <= '0;
         run  <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go) begin
            qr  <= num;
            rr  <= '0;
            dr  <= den;
            cnt <= CW'(W);
            run <= 1'b1;
         end else if (run) begin
            if (rw >= {1'b0, dr}) begin
               rr <= rw_sub[W-1:0];
               qr <= {qr[W-2:0], 1'b1};
            end else begin
               rr <= rw[W-1:0];
               qr <= {qr[W-2:0], 1'b0};
            end
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
               run  <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   assign quo = qr;
   assign rem = rr;
endmodule

// File: rtl/pcs_pl_map.sv
module pcs_pl_map #(
   parameter int BW = 6
) (
   input  logic [BW-1:0] bound,
   output logic [3:0]    idx
);
   import pcs_pkg::*;

   logic [PL_LAST:0] hit;

   for (genvar i = 0; i <= PL_LAST; i++) begin : g_cmp
      assign hit[i] = (BW'(pl_div(4'(i))) >= bound);
   end

   always_comb begin
      idx = 4'(PL_LAST);
      for (int i = PL_LAST; i >= 0; i--) begin
         if (hit[i]) idx = 4'(i);
      end
   end
endmodule

// File: rtl/pll_coef_search.sv
module pll_coef_search #(
   parameter int FW       = 32,
   parameter int MW       = 8,
   parameter int NW       = 8,
   parameter int M_MIN    = 1,
   parameter int M_MAX    = 255,
   parameter int N_MIN    = 8,
   parameter int N_MAX    = 255,
   parameter int PL_MIN   = 1,
   parameter int PL_MAX   = 32,
   parameter int VCO_MIN  = 1000000,
   parameter int VCO_MAX  = 2064000,
   parameter int U_MIN    = 12000,
   parameter int U_MAX    = 38000,
   parameter int F_MIN    = 144000,
   parameter int F_MAX    = 2064000,
   parameter int MARGIN   = 50,
   parameter int RATIO    = 218
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          best_fit,
   input  logic [FW-1:0] req_khz,
   input  logic [FW-1:0] ref_khz,
   output logic          busy,
   output logic          done,
   output logic [MW-1:0] m_div,
   output logic [NW-1:0] n_mul,
   output logic [3:0]    pl_idx,
   output logic [FW-1:0] freq_khz,
   output logic          no_fit
);
   import pcs_pkg::*;

   localparam int DW = FW + MW + 8;
   localparam int BW = 6;
   localparam int LW = DW + 8;

   initial begin
      if (PL_MIN < 1 || PL_MAX > 63 || PL_MIN > PL_MAX)
         $error("pll_coef_search: PL limits out of range");
      if (M_MIN < 1 || M_MAX >= (1 << MW) || N_MAX >= (1 << NW))
         $error("pll_coef_search: M/N limits do not fit their widths");
      if (VCO_MIN > VCO_MAX || F_MIN > F_MAX || MARGIN < 1)
         $error("pll_coef_search: frequency limits inconsistent");
   end

   pcs_state_t    st;
   logic          issued;
   logic [FW-1:0] req_r, ref_r, req_c;
   logic          bf_r;
   logic [DW-1:0] tv_r, vmax_r, tvco_r, n_r, n2_r, vco_r, best_d;
   logic [MW-1:0] m_r, best_m;
   logic [NW-1:0] best_n;
   logic [3:0]    pl_r, pl_hi, best_pl, map_idx;
   logic [5:0]    cur_div, best_div;

   logic          div_state, div_go, div_done;
   logic [DW-1:0] div_num, div_den, div_q, div_rem;
   logic [DW-1:0] vmax_c, delta_c;
   logic [BW-1:0] bound_c;
   logic          vco_in, ratio_ok;

   assign req_c = (req_khz < FW'(F_MIN)) ? FW'(F_MIN) :
                  (req_khz > FW'(F_MAX)) ? FW'(F_MAX) : req_khz;

   assign cur_div  = pl_div(pl_r);
   assign best_div = pl_div(best_pl);
   assign vmax_c   = (DW'(VCO_MAX) < tv_r) ? tv_r : DW'(VCO_MAX);
   assign bound_c  = (div_q < DW'(PL_MIN)) ? BW'(PL_MIN) :
                     (div_q > DW'(PL_MAX)) ? BW'(PL_MAX) : div_q[BW-1:0];
   assign delta_c  = (div_q > DW'(req_r)) ? div_q - DW'(req_r) : DW'(req_r) - div_q;
   assign ratio_ok = LW'(vco_r) >= LW'(delta_c) * LW'(RATIO + 1);
   assign vco_in   = (div_q >= DW'(VCO_MIN)) && (div_q <= vmax_r);

   assign div_state = (st == S_TGT) || (st == S_WHI) || (st == S_WLO) ||
                      (st == S_MUF) || (st == S_MN) || (st == S_NVCO) ||
                      (st == S_NLWV) || (st == S_FIN);
   assign div_go    = div_state && !issued;
   assign busy      = (st != S_IDLE);

   always_comb begin
      div_num = '0;
      div_den = DW'(1);
      case (st)
         S_TGT:  begin div_num = DW'(req_r);           div_den = DW'(MARGIN); end
         S_WHI:  begin div_num = vmax_c + tv_r - 1'b1;  div_den = tv_r; end
         S_WLO:  begin div_num = DW'(VCO_MIN);         div_den = tv_r; end
         S_MUF:  begin div_num = DW'(ref_r);           div_den = DW'(m_r); end
         S_MN:   begin div_num = tvco_r * DW'(m_r);    div_den = DW'(ref_r); end
         S_NVCO: begin div_num = DW'(ref_r) * n_r;     div_den = DW'(m_r); end
         S_NLWV: begin div_num = vco_r + DW'(cur_div >> 1); div_den = DW'(cur_div); end
         S_FIN:  begin div_num = DW'(ref_r) * DW'(best_n);
                       div_den = DW'(best_m) * DW'(best_div); end
         default: ;
      endcase
   end

   pcs_divider #(.W(DW)) u_div (
      .clk (clk), .rst_n (rst_n), .go (div_go),
      .num (div_num), .den (div_den),
      .quo (div_q), .rem (div_rem), .done (div_done)
   );

   pcs_pl_map #(.BW(BW)) u_map (.bound (bound_c), .idx (map_idx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         issued   <= 1'b0;
         req_r    <= '0;
         ref_r    <= '0;
         bf_r     <= 1'b0;
         tv_r     <= '0;
         vmax_r   <= '0;
         tvco_r   <= '0;
         n_r      <= '0;
         n2_r     <= '0;
         vco_r    <= '0;
         m_r      <= '0;
         pl_r     <= '0;
         pl_hi    <= '0;
         best_m   <= MW'(M_MAX);
         best_n   <= NW'(N_MIN);
         best_pl  <= 4'(PL_MIN);
         best_d   <= '1;
         done     <= 1'b0;
         m_div    <= MW'(M_MAX);
         n_mul    <= NW'(N_MIN);
         pl_idx   <= 4'(PL_MIN);
         freq_khz <= '0;
         no_fit   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (div_go) issued <= 1'b1;
         if (div_done) issued <= 1'b0;
         case (st)
            S_IDLE: if (start) begin
               req_r   <= req_c;
               ref_r   <= ref_khz;
               bf_r    <= best_fit;
               best_m  <= MW'(M_MAX);
               best_n  <= NW'(N_MIN);
               best_pl <= 4'(PL_MIN);
               best_d  <= '1;
               st      <= S_TGT;
            end
            S_TGT: if (div_done) begin
               tv_r <= DW'(req_r) + div_q;
               st   <= S_WHI;
            end
            S_WHI: if (div_done) begin
               vmax_r <= vmax_c;
               pl_hi  <= map_idx;
               st     <= S_WLO;
            end
            S_WLO: if (div_done) begin
               pl_r <= map_idx;
               st   <= S_PLSET;
            end
            S_PLSET: begin
               tvco_r <= DW'(req_r) * DW'(cur_div);
               m_r    <= MW'(M_MIN);
               st     <= S_MUF;
            end
            S_MUF: if (div_done) begin
               if (div_q < DW'(U_MIN))      st <= S_NXTPL;
               else if (div_q > DW'(U_MAX)) st <= S_NXTM;
               else                         st <= S_MN;
            end
            S_MN: if (div_done) begin
               n_r  <= div_q;
               n2_r <= div_q + DW'(div_rem != '0);
               st   <= (div_q > DW'(N_MAX)) ? S_NXTPL : S_NCHK;
            end
            S_NCHK: begin
               if (n_r > n2_r)              st  <= S_NXTM;
               else if (n_r < DW'(N_MIN))   n_r <= n_r + 1'b1;
               else if (n_r > DW'(N_MAX))   st  <= S_NXTM;
               else                         st  <= S_NVCO;
            end
            S_NVCO: if (div_done) begin
               vco_r <= div_q;
               if (vco_in) st <= S_NLWV;
               else begin
                  n_r <= n_r + 1'b1;
                  st  <= S_NCHK;
               end
            end
            S_NLWV: if (div_done) begin
               n_r <= n_r + 1'b1;
               st  <= S_NCHK;
               if (delta_c < best_d) begin
                  best_d  <= delta_c;
                  best_m  <= m_r;
                  best_n  <= n_r[NW-1:0];
                  best_pl <= pl_r;
                  if (delta_c == '0 || (!bf_r && ratio_ok)) st <= S_FIN;
               end
            end
            S_NXTM: begin
               if (m_r == MW'(M_MAX)) st <= S_NXTPL;
               else begin
                  m_r <= m_r + 1'b1;
                  st  <= S_MUF;
               end
            end
            S_NXTPL: begin
               if (pl_r >= pl_hi) st <= S_FIN;
               else begin
                  pl_r <= pl_r + 1'b1;
                  st   <= S_PLSET;
               end
            end
            S_FIN: if (div_done) begin
               m_div    <= best_m;
               n_mul    <= best_n;
               pl_idx   <= best_pl;
               freq_khz <= div_q[FW-1:0];
               no_fit   <= (best_d == '1);
               done     <= 1'b1;
               st       <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
   parameter int MW     = 8,
   parameter int NW     = 8,
   parameter int FW     = 32,
   parameter int M_MIN  = 1,
   parameter int M_MAX  = 255,
   parameter int N_MIN  = 8,
   parameter int N_MAX  = 255,
   parameter int PL_MIN = 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          done,
   input logic [MW-1:0] m_div,
   input logic [NW-1:0] n_mul,
   input logic [3:0]    pl_idx,
   input logic [FW-1:0] freq_khz,
   input logic          no_fit
);
   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);                                   // R2
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                              // R2
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);                                              // R2
   AST_FIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !no_fit) |-> (m_div >= MW'(M_MIN) && m_div <= MW'(M_MAX) &&
                             n_mul >= NW'(N_MIN) && n_mul <= NW'(N_MAX) &&
                             pl_idx <= 4'd13));                      // R6
   AST_NOFIT_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      (done && no_fit) |-> (m_div == MW'(M_MAX) && n_mul == NW'(N_MIN) &&
                            pl_idx == 4'(PL_MIN)));                  // R11
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(m_div) && $stable(n_mul) && $stable(pl_idx) &&
                 $stable(freq_khz) && $stable(no_fit)));             // R12
endmodule

bind pll_coef_search pcs_checker #(
   .MW(MW), .NW(NW), .FW(FW), .M_MIN(M_MIN), .M_MAX(M_MAX),
   .N_MIN(N_MIN), .N_MAX(N_MAX), .PL_MIN(PL_MIN)
) u_pcs_checker (
   .clk (clk), .rst_n (rst_n), .start (start), .busy (busy), .done (done),
   .m_div (m_div), .n_mul (n_mul), .pl_idx (pl_idx),
   .freq_khz (freq_khz), .no_fit (no_fit)
);

// File: tb/test_pll_coef_search.sv
`timescale 1ns/1ps
module test_pll_coef_search;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        best_fit = 1'b1;
   logic [31:0] req_khz = '0;
   logic [31:0] ref_khz = '0;
   logic        busy, done, no_fit;
   logic [7:0]  m_div, n_mul;
   logic [3:0]  pl_idx;
   logic [31:0] freq_khz;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   pll_coef_search i_pll_coef_search (
      .clk (clk), .rst_n (rst_n), .start (start), .best_fit (best_fit),
      .req_khz (req_khz), .ref_khz (ref_khz), .busy (busy), .done (done),
      .m_div (m_div), .n_mul (n_mul), .pl_idx (pl_idx),
      .freq_khz (freq_khz), .no_fit (no_fit)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic longint tdiv(input longint i);
      case (i)
         0: return 1;   1: return 2;   2: return 3;   3: return 4;
         4: return 5;   5: return 6;   6: return 8;   7: return 10;
         8: return 12;  9: return 16;  10: return 12; 11: return 16;
         12: return 20; 13: return 24; default: return 32;
      endcase
   endfunction

   // Independent search model built from the requirement text.
   task automatic model(input longint rq, input longint rf, input bit bf,
                        output longint em, output longint en, output longint ep,
                        output longint ef, output bit ee);
      longint r, tv, vmax, hi, lo, bm, bn, bp, bd, tvco, uf, n, n2, vco, lwv, d;
      longint ilo, ihi;
      bit stop;
      r = (rq < 144000) ? 144000 : ((rq > 2064000) ? 2064000 : rq);
      tv = r + r / 50;
      vmax = (2064000 < tv) ? tv : 2064000;
      hi = (vmax + tv - 1) / tv;
      lo = 1000000 / tv;
      if (hi < 1) hi = 1;
      if (hi > 32) hi = 32;
      if (lo < 1) lo = 1;
      if (lo > 32) lo = 32;
      ilo = 13; ihi = 13;
      for (int i = 13; i >= 0; i--) begin
         if (tdiv(i) >= lo) ilo = i;
         if (tdiv(i) >= hi) ihi = i;
      end
      bm = 255; bn = 8; bp = 1; bd = 64'h7fff_ffff_ffff_ffff; stop = 0;
      for (longint p = ilo; p <= ihi && !stop; p++) begin
         tvco = r * tdiv(p);
         for (longint m = 1; m <= 255 && !stop; m++) begin
            uf = rf / m;
            if (uf < 12000) break;
            if (uf > 38000) continue;
            n  = tvco * m / rf;
            n2 = (tvco * m + rf - 1) / rf;
            if (n > 255) break;
            for (; n <= n2 && !stop; n++) begin
               if (n < 8) continue;
               if (n > 255) break;
               vco = rf * n / m;
               if (vco >= 1000000 && vco <= vmax) begin
                  lwv = (vco + tdiv(p) / 2) / tdiv(p);
                  d = (lwv > r) ? lwv - r : r - lwv;
                  if (d < bd) begin
                     bd = d; bm = m; bn = n; bp = p;
                     if (d == 0 || (!bf && vco / d > 218)) stop = 1;
                  end
               end
            end
         end
      end
      em = bm; en = bn; ep = bp;
      ee = (bd == 64'h7fff_ffff_ffff_ffff);
      ef = rf * bn / (bm * tdiv(bp));
   endtask

   task automatic wait_done(input string tag);
      int n = 0;
      while (!done && n < 60000) begin
         @(negedge clk);
         n++;
      end
      check(done == 1'b1, {tag, " R2 done seen"}, done, 1);
   endtask

   task automatic run_search(input longint rq, input longint rf, input bit bf, input string tag);
      @(negedge clk);
      req_khz = 32'(rq); ref_khz = 32'(rf); best_fit = bf; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, {tag, " R2 busy after start"}, busy, 1);
      wait_done(tag);
      check(busy == 1'b0, {tag, " R2 busy low with done"}, busy, 0);
   endtask

   task automatic expect_out(input string tag, input longint em, input longint en,
                             input longint ep, input longint ef, input bit ee);
      check(m_div == em, {tag, " M"}, m_div, em);
      check(n_mul == en, {tag, " N"}, n_mul, en);
      check(pl_idx == ep, {tag, " PL"}, pl_idx, ep);
      check(freq_khz == ef, {tag, " freq R10"}, freq_khz, ef);
      check(no_fit == ee, {tag, " error flag"}, no_fit, ee);
   endtask

   task automatic vs_model(input longint rq, input longint rf, input bit bf, input string tag);
      longint em, en, ep, ef;
      bit ee;
      model(rq, rf, bf, em, en, ep, ef, ee);
      run_search(rq, rf, bf, tag);
      expect_out(tag, em, en, ep, ef, ee);
   endtask

   task automatic t_reset();
      check(busy == 0, "R1 busy", busy, 0);
      check(done == 0, "R1 done", done, 0);
      check(m_div == 255, "R1 m_div", m_div, 255);
      check(n_mul == 8, "R1 n_mul", n_mul, 8);
      check(pl_idx == 1, "R1 pl_idx", pl_idx, 1);
      check(freq_khz == 0, "R1 freq", freq_khz, 0);
      check(no_fit == 0, "R1 no_fit", no_fit, 0);
   endtask

   task automatic t_exact();
      // index 1 vco 960000 rejected (R7), index 2 exact (R4, R8)
      run_search(480000, 12000, 1, "R8 exact");
      expect_out("R8 exact R4 R7", 1, 120, 2, 480000, 0);
   endtask

   task automatic t_ratio();
      run_search(500000, 12000, 0, "R9 ratio");
      expect_out("R9 ratio stop", 1, 84, 1, 504000, 0);
      run_search(500000, 12000, 1, "R8 bestfit");
      expect_out("R8 bestfit continues", 1, 125, 2, 500000, 0);
   endtask

   task automatic t_clamp();
      run_search(100000, 12000, 1, "R3 low");
      expect_out("R3 low clamp", 1, 96, 6, 144000, 0);
      run_search(3000000, 12000, 1, "R3 high");
      expect_out("R3 high clamp R4 vmax raised", 1, 172, 0, 2064000, 0);
   endtask

   task automatic t_nofit();
      run_search(480000, 10000, 1, "R11 nofit");
      expect_out("R11 nofit R5 min comparison", 255, 8, 1, 156, 1);
   endtask

   task automatic t_skip_m();
      vs_model(700000, 50000, 1, "R5 skip fast M");
      check(m_div != 1, "R5 M=1 skipped", m_div, 2);
   endtask

   task automatic t_model_mix();
      vs_model(700000, 38000, 1, "R6 ref38000");
      vs_model(333333, 27000, 1, "R7 ref27000 bf");
      vs_model(333333, 27000, 0, "R9 ref27000 ratio");
      vs_model(1000001, 19200, 1, "R10 ref19200");
      vs_model(777777, 13000, 0, "R6 ref13000");
   endtask

   task automatic t_busy_ignore();
      longint em, en, ep, ef;
      bit ee;
      model(480000, 12000, 1, em, en, ep, ef, ee);
      @(negedge clk);
      req_khz = 480000; ref_khz = 12000; best_fit = 1; start = 1;
      @(negedge clk);
      start = 0;
      repeat (5) @(negedge clk);
      req_khz = 900000; best_fit = 0; start = 1;
      @(negedge clk);
      start = 0;
      wait_done("R2 ignore");
      expect_out("R2 start while busy ignored", em, en, ep, ef, ee);
   endtask

   task automatic t_hold();
      longint m0, f0;
      m0 = m_div; f0 = freq_khz;
      req_khz = 1500000; ref_khz = 38000;
      repeat (30) @(negedge clk);
      check(m_div == m0, "R12 hold M", m_div, m0);
      check(freq_khz == f0, "R12 hold freq", freq_khz, f0);
      check(busy == 0, "R12 no start no busy", busy, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_exact();
      t_ratio();
      t_clamp();
      t_nofit();
      t_skip_m();
      t_model_mix();
      t_busy_ignore();
      t_hold();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog R2: actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule